// File: doc/BRIEF.md
# Ripple Up/Down Binary Counter

This block is a modulo-8 binary counter made from a chain of three toggle flip-flops, with no shared counting clock. The lowest stage is clocked directly by the input clock. Each later stage takes as its clock a signal built from the stage just below it. Every stage changes state on the falling edge of its own clock, so a change at the bottom of the chain ripples upward through the stages one after another.

A per-stage AND-OR selector chooses the clock for the next stage. It passes either the true output of the lower stage or its complement, as set by a single direction pin. With the true output selected, a stage toggles when the stage below falls from 1 to 0, and the count goes up. With the complement selected, a stage toggles when the stage below rises from 0 to 1, and the count goes down. An active-low asynchronous reset clears every stage at once.

The selector has no glitch filter, so changing the direction can itself produce a clock edge. The direction pin should therefore only be changed while reset is held low. Software reads the count only after the ripple has settled, which in practice means half a clock period after a falling edge.

Top module: `rip_updown_counter`

## Requirements
- R1: While `rst_n` is high, bit 0 of `count_o` (the first stage) inverts on every falling edge of `clk_in`.
- R2: Bit k of `count_o` is stage k+1. A stage changes state only on a falling edge of its own selected clock, so the upper bits change only when the bit below them changes.
- R3: When counting up, the count that follows 7 is 0.
- R4: With `dn_i` = 0 (up), each stage is clocked by the true output of the stage below it, and the settled count rises by exactly 1 per falling edge of `clk_in`.
- R5: With `dn_i` = 1 (down), each stage is clocked by the complement of the stage below it, and the settled count falls by exactly 1 per falling edge. The count that follows 0 is 7.
- R6: A low level on `rst_n` forces `count_o` to 0 at once, with no clock edge needed, and holds it at 0 for as long as `rst_n` stays low.
- R7: After reset is released, the first falling edge of `clk_in` gives 1 when counting up and 7 when counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Count clock; the first stage toggles on its falling edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| dn_i | input | 1 | Direction: 0 counts up, 1 counts down; change it only while `rst_n` is low |
| count_o | output | 3 | Count value; bit 0 is the first stage |

## Verification
The bench goes after the two wrap points: 7 to 0 going up and 0 to 7 going down. If the selector polarity were swapped, or a stage were wired to the wrong neighbour, the count would step the wrong way or skip values at exactly these points. It checks that reset clears the count in the middle of a clock period with no edge. A reset synchronous to the clock would leave the old count visible there. It also runs long sequences of 8 and 16 steps that must land back on their start value. A chain that lost or gained an edge somewhere, for example a stage triggered on the rising edge, would drift away from the reference count.

// File: rtl/rip_pkg.sv
package rip_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/rip_clk_sel.sv
// AND-OR clock selector for one upper stage: passes the lower stage's
// true output when counting up and its complement when counting down.
module rip_clk_sel
  import rip_pkg::*;
(
  input  logic q_low_i,
  input  logic dn_i,
  output logic sclk_o
);
  logic go_down;
  logic term_up;
  logic term_dn;

  assign go_down = (dn_i == DIR_DOWN);
  assign term_up = q_low_i & ~go_down;
  assign term_dn = ~q_low_i & go_down;
  assign sclk_o  = term_up | term_dn;
endmodule

// File: rtl/rip_tff_stage.sv
// One toggle stage: inverts on the falling edge of its own clock.
module rip_tff_stage (
  input  logic tclk_i,
  input  logic rst_ni,
  output logic q_o
);
  always_ff @(negedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= ~q_o;
  end
endmodule

// File: rtl/rip_updown_counter.sv
module rip_updown_counter
  import rip_pkg::*;
#(
  parameter int NSTAGES = 3
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               dn_i,
  output logic [NSTAGES-1:0] count_o
);
  localparam logic [NSTAGES-1:0] TOP_VAL = {NSTAGES{1'b1}};

  logic [NSTAGES-1:0] stage_clk;
  logic [NSTAGES-1:0] stage_q;

  assign stage_clk[0] = clk_in;

  for (genvar k = 1; k < NSTAGES; k++) begin : g_sel
    rip_clk_sel u_sel (
      .q_low_i (stage_q[k-1]),
      .dn_i    (dn_i),
      .sclk_o  (stage_clk[k])
    );
  end

  for (genvar k = 0; k < NSTAGES; k++) begin : g_stage
    rip_tff_stage u_ff (
      .tclk_i (stage_clk[k]),
      .rst_ni (rst_n),
      .q_o    (stage_q[k])
    );
  end

  assign count_o = stage_q;

  // R4: one step up per falling edge while direction held up
  p_up_step_r4: assert property (@(negedge clk_in) disable iff (!rst_n)
    (dn_i == DIR_UP) ##1 (dn_i == DIR_UP)
    |-> count_o == NSTAGES'($past(count_o) + 1'b1));

  // R5: one step down per falling edge while direction held down
  p_down_step_r5: assert property (@(negedge clk_in) disable iff (!rst_n)
    (dn_i == DIR_DOWN) ##1 (dn_i == DIR_DOWN)
    |-> count_o == NSTAGES'($past(count_o) - 1'b1));

  // R3: top value wraps to zero when counting up
  p_wrap_up_r3: assert property (@(negedge clk_in) disable iff (!rst_n)
    ((dn_i == DIR_UP) && count_o == TOP_VAL) ##1 (dn_i == DIR_UP)
    |-> count_o == '0);

  // R5: zero wraps to top value when counting down
  p_wrap_down_r5: assert property (@(negedge clk_in) disable iff (!rst_n)
    ((dn_i == DIR_DOWN) && count_o == '0) ##1 (dn_i == DIR_DOWN)
    |-> count_o == TOP_VAL);

  // R6: count is zero whenever reset is held
  p_reset_clear_r6: assert property (@(posedge clk_in)
    !rst_n |-> count_o == '0);
endmodule

// File: tb/sim_rip_updown_counter.sv
`timescale 1ns/1ps
module sim_rip_updown_counter;
  logic       clk_in = 1'b0;
  logic       rst_n;
  logic       dn_i;
  logic [2:0] count_o;

  int checks = 0;
  int errors = 0;
  logic [2:0] model = 3'd0;
  logic [2:0] prev;
  logic       done = 1'b0;

  rip_updown_counter #(.NSTAGES(3)) u0 (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .dn_i    (dn_i),
    .count_o (count_o)
  );

  always #10 clk_in = ~clk_in;

  // vector: {reset_first, dir, steps[4:0], expected[2:0]}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd3,  3'd3},   // R4 up from reset
    {1'b0, 1'b0, 5'd4,  3'd7},   // R4
    {1'b0, 1'b0, 5'd1,  3'd0},   // R3 wrap up
    {1'b0, 1'b0, 5'd9,  3'd1},   // R3 wrap again
    {1'b1, 1'b1, 5'd1,  3'd7},   // R5/R7 first down step
    {1'b0, 1'b1, 5'd3,  3'd4},   // R5
    {1'b0, 1'b1, 5'd4,  3'd0},   // R5
    {1'b0, 1'b1, 5'd1,  3'd7},   // R5 wrap down
    {1'b1, 1'b0, 5'd8,  3'd0},   // R3 full cycle up
    {1'b1, 1'b1, 5'd16, 3'd0}    // R5 two cycles down
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic d);
    @(posedge clk_in);
    #2 rst_n = 1'b0;
    #1 chk(count_o == 3'd0, "R6", count_o, 0);
    dn_i = d;
    @(posedge clk_in);
    #2 rst_n = 1'b1;
    model = 3'd0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      prev = count_o;
      @(negedge clk_in);
      model = dn_i ? model - 3'd1 : model + 3'd1;
      @(posedge clk_in);
      chk(count_o == model, dn_i ? "R5" : "R4", count_o, model);
      chk(count_o[0] != prev[0], "R1", count_o[0], ~prev[0]);
      // R2: bit k changes only if bit k-1 changed
      chk(!((count_o[1] != prev[1]) && (count_o[0] == prev[0])) &&
          !((count_o[2] != prev[2]) && (count_o[1] == prev[1])),
          "R2", count_o, model);
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    dn_i  = 1'b0;
    #25;
    chk(count_o == 3'd0, "R6", count_o, 0);
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][9]) do_reset(VEC[v][8]);
      step(int'(VEC[v][7:3]));
      chk(count_o == VEC[v][2:0], "R3/R4/R5 table", count_o, VEC[v][2:0]);
    end

    // R7: first edge after reset, up gives 1
    do_reset(1'b0);
    step(1);
    chk(count_o == 3'd1, "R7", count_o, 1);
    // R7: first edge after reset, down gives 7
    do_reset(1'b1);
    step(1);
    chk(count_o == 3'd7, "R7", count_o, 7);

    // R6: asynchronous clear in mid-period, no edge, held while low
    do_reset(1'b0);
    step(5);
    @(posedge clk_in);
    #3 rst_n = 1'b0;
    #1 chk(count_o == 3'd0, "R6 async", count_o, 0);
    repeat (3) @(negedge clk_in);
    #1 chk(count_o == 3'd0, "R6 held", count_o, 0);
    @(posedge clk_in);
    #2 rst_n = 1'b1;
    model = 3'd0;
    step(2);
    chk(count_o == 3'd2, "R4 after R6", count_o, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule